// File: doc/BRIEF.md
# Bus Breakpoint Wait-State Controller

This block sits beside a small processor's external bus and holds the CPU in a wait state when a breakpoint is hit. It keeps two loadable breakpoint values, one for the address bus and one for the data bus. It compares the bus with both of them and drives the CPU's READY input low to stop the machine. A front panel then advances the CPU one step at a time with a step pulse.

The two breakpoints behave differently because the CPU looks at READY only during a short window. That window is the clock after the address-latch strobe, or any clock while the CPU is already waiting. An address hit is caught while the address is being latched, so READY is already low in that same bus cycle's window. The CPU stops with the breakpoint address on the bus.

A data hit can happen anywhere in an instruction. It sets a sticky pending flag and pulls READY low at once. The CPU ignores this until its next sampling window, so it stops one bus cycle later than the matching byte. The byte on the bus at the stop is then usually not the pattern that triggered it.

Top module: `bus_bp_wait`

## Requirements
- R1: With the address compare enabled, a clock with `aleStrobe` high and `addrBus` equal to the address breakpoint drives `ready` low in the next clock, which is the CPU sampling window. Addresses are compared only on clocks with `aleStrobe` high.
- R2: With the data compare enabled, a clock with `rdStrobe` or `wrStrobe` high and `dataBus` equal to the data breakpoint drives `dataPendingN` low (active) in the next clock. Reads and writes are treated alike.
- R3: Once active, `dataPendingN` stays low until a step pulse or reset, even after the matching byte has left the bus.
- R4: `ready` is low in every clock where `dataPendingN` is low, starting in the clock where the flag first goes low. The one exception is the release clock that follows a step pulse.
- R5: `stopped` goes high only at the end of a sampling window in which `ready` is low. It is first seen high two clocks after the `aleStrobe` clock, and it stays high while the CPU waits.
- R6: A data hit in the middle of a bus cycle does not raise `stopped` by itself. `stopped` rises two clocks after the next `aleStrobe`.
- R7: A one-clock `stepPulse` clears the pending flag, the address hold and `stopped`. It drives `ready` high for exactly the next clock. After that, `ready` goes low again if `stepMode` is high.
- R8: While `addrEnable` or `dataEnable` is low, the matching compare never pulls `ready` low and never sets the pending flag.
- R9: A data bus value equal to the breakpoint while both `rdStrobe` and `wrStrobe` are low causes no hit.
- R10: While `rst` is high, `ready` is high even if `stepMode` is high. In the clock after a reset clock, `dataPendingN` is high and `stopped` is low.
- R11: A load strobe writes its value into its breakpoint register at the clock edge. The new value is used for compares from the next clock on.
- R12: If a data hit and `stepPulse` arrive in the same clock, the hit wins and the pending flag is active in the next clock. That next clock is still the one-clock `ready` release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addrBus | input | ADDR_W | Address bus |
| dataBus | input | DATA_W | Data bus |
| rdStrobe | input | 1 | Read transfer active |
| wrStrobe | input | 1 | Write transfer active |
| aleStrobe | input | 1 | Address latch strobe; the next clock is a READY sampling window |
| addrBpLoad | input | 1 | Load the address breakpoint |
| addrBpValue | input | ADDR_W | Value for the address breakpoint |
| dataBpLoad | input | 1 | Load the data breakpoint |
| dataBpValue | input | DATA_W | Value for the data breakpoint |
| addrEnable | input | 1 | Enable the address compare |
| dataEnable | input | 1 | Enable the data compare |
| stepMode | input | 1 | Hold READY low at every sampling window |
| stepPulse | input | 1 | One-clock step/resume request |
| ready | output | 1 | READY to the CPU, low requests a wait |
| dataPendingN | output | 1 | Data match pending, active low |
| stopped | output | 1 | CPU is held in a wait state |

## Verification
The data compare is swept over all 256 byte values, with reads and writes alternating. This separates a true pattern match from near misses and shows that both transfer directions are compared. The same byte sweep is run with no strobe active and again with the data compare disabled, which must give no hits. The address compare is swept over every low byte around the breakpoint. Further cases cover a match without a latch strobe, a disabled compare and a reloaded breakpoint, so that an exact stop can be told apart from a false or stale one. Directed sequences then place a data hit in the middle of a bus cycle, step with and without step mode, and put a hit and a step pulse in the same clock. These show when the stop actually takes hold and when it is released.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  typedef struct packed {
    logic addrHit;
    logic dataHit;
  } bpHits_t;
endpackage

// File: rtl/bpw_match_reg.sv
// Loadable compare register: hit when qualified and bus equals stored value.
module bpw_match_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] loadValue,
  input  logic [W-1:0] busValue,
  input  logic         qualify,
  output logic         hit
);
  logic [W-1:0] stored;

  always_ff @(posedge clk) begin
    if (rst)       stored <= '0;
    else if (load) stored <= loadValue;
  end

  assign hit = qualify && (busValue == stored);
endmodule

// File: rtl/bpw_datapath.sv
module bpw_datapath
  import bpw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              aleStrobe,
  input  logic              addrBpLoad,
  input  logic [ADDR_W-1:0] addrBpValue,
  input  logic              dataBpLoad,
  input  logic [DATA_W-1:0] dataBpValue,
  input  logic              addrEnable,
  input  logic              dataEnable,
  output bpHits_t           hits
);
  logic addrQual;
  logic dataQual;

  // Address is valid only while being latched; data only during a transfer.
  assign addrQual = addrEnable && aleStrobe;
  assign dataQual = dataEnable && (rdStrobe || wrStrobe);

  bpw_match_reg #(.W(ADDR_W)) i_addrMatch (
    .clk(clk), .rst(rst),
    .load(addrBpLoad), .loadValue(addrBpValue),
    .busValue(addrBus), .qualify(addrQual),
    .hit(hits.addrHit)
  );

  bpw_match_reg #(.W(DATA_W)) i_dataMatch (
    .clk(clk), .rst(rst),
    .load(dataBpLoad), .loadValue(dataBpValue),
    .busValue(dataBus), .qualify(dataQual),
    .hit(hits.dataHit)
  );
endmodule

// File: rtl/bpw_control.sv
module bpw_control
  import bpw_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  bpHits_t hits,
  input  logic    aleStrobe,
  input  logic    stepMode,
  input  logic    stepPulse,
  output logic    ready,
  output logic    dataPendingN,
  output logic    stopped
);
  logic aleQ;       // clock after the latch strobe: CPU samples READY
  logic addrHold;   // exact-address stop request
  logic dataPend;   // sticky data-pattern hit
  logic stopQ;      // CPU is in a wait state
  logic releaseQ;   // one-clock release after a step pulse
  logic holdReq;
  logic sampleWin;

  assign sampleWin = aleQ || stopQ;
  assign holdReq   = addrHold || dataPend || stepMode;
  assign ready     = rst || releaseQ || !holdReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      aleQ     <= 1'b0;
      addrHold <= 1'b0;
      dataPend <= 1'b0;
      stopQ    <= 1'b0;
      releaseQ <= 1'b0;
    end else begin
      aleQ     <= aleStrobe;
      releaseQ <= stepPulse;
      // New hits take priority over a clearing step pulse.
      addrHold <= hits.addrHit || (addrHold && !stepPulse);
      dataPend <= hits.dataHit || (dataPend && !stepPulse);
      stopQ    <= !stepPulse && (stopQ || (sampleWin && !ready));
    end
  end

  assign dataPendingN = !dataPend;
  assign stopped      = stopQ;
endmodule

// File: rtl/bus_bp_wait.sv
module bus_bp_wait
  import bpw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addrBus,
  input  logic [DATA_W-1:0] dataBus,
  input  logic              rdStrobe,
  input  logic              wrStrobe,
  input  logic              aleStrobe,
  input  logic              addrBpLoad,
  input  logic [ADDR_W-1:0] addrBpValue,
  input  logic              dataBpLoad,
  input  logic [DATA_W-1:0] dataBpValue,
  input  logic              addrEnable,
  input  logic              dataEnable,
  input  logic              stepMode,
  input  logic              stepPulse,
  output logic              ready,
  output logic              dataPendingN,
  output logic              stopped
);
  bpHits_t hits;

  bpw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rst(rst),
    .addrBus(addrBus), .dataBus(dataBus),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .aleStrobe(aleStrobe),
    .addrBpLoad(addrBpLoad), .addrBpValue(addrBpValue),
    .dataBpLoad(dataBpLoad), .dataBpValue(dataBpValue),
    .addrEnable(addrEnable), .dataEnable(dataEnable),
    .hits(hits)
  );

  bpw_control i_control (
    .clk(clk), .rst(rst),
    .hits(hits), .aleStrobe(aleStrobe),
    .stepMode(stepMode), .stepPulse(stepPulse),
    .ready(ready), .dataPendingN(dataPendingN), .stopped(stopped)
  );
endmodule

// File: rtl/bpw_checker.sv
module bpw_checker (
  input logic clk,
  input logic rst,
  input logic aleStrobe,
  input logic dataEnable,
  input logic stepPulse,
  input logic ready,
  input logic dataPendingN,
  input logic stopped
);
  // R3: pending flag holds until a step pulse
  a_r3_pending_sticky: assert property (@(posedge clk) disable iff (rst)
    (!dataPendingN && !stepPulse) |=> !dataPendingN);

  // R4: READY low while pending, except in the release clock
  a_r4_ready_follows_pending: assert property (@(posedge clk) disable iff (rst)
    (!dataPendingN && !$past(stepPulse)) |-> !ready);

  // R5: stop takes hold only two clocks after a latch strobe
  a_r5_stop_in_window: assert property (@(posedge clk) disable iff (rst)
    $rose(stopped) |-> $past(aleStrobe, 2));

  // R7: a step pulse releases READY and clears the stop
  a_r7_step_release: assert property (@(posedge clk) disable iff (rst)
    stepPulse |=> (ready && !stopped));

  // R8: disabled data compare never raises the pending flag
  a_r8_data_disabled: assert property (@(posedge clk) disable iff (rst)
    (dataPendingN && !dataEnable) |=> dataPendingN);

  // R10: reset forces READY high and clears state
  a_r10_reset_ready: assert property (@(posedge clk) rst |-> ready);
  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (dataPendingN && !stopped));
endmodule

bind bus_bp_wait bpw_checker i_bpwChecker (
  .clk(clk), .rst(rst), .aleStrobe(aleStrobe), .dataEnable(dataEnable),
  .stepPulse(stepPulse), .ready(ready), .dataPendingN(dataPendingN),
  .stopped(stopped)
);

// File: tb/test_bus_bp_wait.sv
module test_bus_bp_wait;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] ABP  = 16'h1234;
  localparam logic [AW-1:0] ABP2 = 16'hBEEF;
  localparam logic [DW-1:0] DBP  = 8'hA5;

  logic clk = 1'b0;
  logic rst;
  logic [AW-1:0] addrBus;
  logic [DW-1:0] dataBus;
  logic rdStrobe, wrStrobe, aleStrobe;
  logic addrBpLoad, dataBpLoad;
  logic [AW-1:0] addrBpValue;
  logic [DW-1:0] dataBpValue;
  logic addrEnable, dataEnable, stepMode, stepPulse;
  logic ready, dataPendingN, stopped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_bp_wait #(.ADDR_W(AW), .DATA_W(DW)) i_bus_bp_wait (
    .clk(clk), .rst(rst), .addrBus(addrBus), .dataBus(dataBus),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .aleStrobe(aleStrobe),
    .addrBpLoad(addrBpLoad), .addrBpValue(addrBpValue),
    .dataBpLoad(dataBpLoad), .dataBpValue(dataBpValue),
    .addrEnable(addrEnable), .dataEnable(dataEnable),
    .stepMode(stepMode), .stepPulse(stepPulse),
    .ready(ready), .dataPendingN(dataPendingN), .stopped(stopped)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    stepPulse = 1'b1;
    tick();
    stepPulse = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; addrBus = '0; dataBus = '0;
    rdStrobe = 0; wrStrobe = 0; aleStrobe = 0;
    addrBpLoad = 0; dataBpLoad = 0; addrBpValue = '0; dataBpValue = '0;
    addrEnable = 0; dataEnable = 0; stepMode = 1'b1; stepPulse = 0;
    @(negedge clk);
    tick();
    // R10: reset overrides step mode and clears state
    check("R10 ready in reset", ready, 1);
    check("R10 pending in reset", dataPendingN, 1);
    check("R10 stopped in reset", stopped, 0);
    rst = 1'b0; stepMode = 1'b0;

    // R11: load breakpoints
    dataBpLoad = 1; dataBpValue = DBP; addrBpLoad = 1; addrBpValue = ABP;
    tick();
    dataBpLoad = 0; addrBpLoad = 0;

    // R2: full byte sweep, alternating read and write
    dataEnable = 1;
    for (int v = 0; v < 256; v++) begin
      bit hit;
      dataBus = v[DW-1:0];
      rdStrobe = v[0]; wrStrobe = !v[0];
      tick();
      rdStrobe = 0; wrStrobe = 0;
      hit = (v == int'(DBP));
      check("R2 pending after byte", dataPendingN, hit ? 0 : 1);
      check("R4 ready with pending", ready, hit ? 0 : 1);
      if (hit) begin
        dataBus = '0;
        tick(); tick();
        check("R3 pending sticky", dataPendingN, 0);
        check("R4 ready held low", ready, 0);
        check("R6 no stop without window", stopped, 0);
        step();
        check("R7 pending cleared", dataPendingN, 1);
        check("R7 release clock", ready, 1);
        tick();
        check("R7 ready stays high without step mode", ready, 1);
      end
    end

    // R9: matching byte with no transfer strobe
    for (int v = 0; v < 256; v++) begin
      dataBus = v[DW-1:0];
      tick();
      check("R9 no hit without strobe", dataPendingN, 1);
    end

    // R8: data compare disabled
    dataEnable = 0;
    for (int v = 0; v < 256; v++) begin
      dataBus = v[DW-1:0]; rdStrobe = 1;
      tick();
      check("R8 data disabled no pending", dataPendingN, 1);
      check("R8 data disabled ready", ready, 1);
    end
    rdStrobe = 0;

    // R1 / R5: address sweep around breakpoint
    addrEnable = 1;
    for (int lo = 0; lo < 257; lo++) begin
      logic [AW-1:0] a;
      bit hit;
      a = (lo == 256) ? 16'h1334 : {8'h12, lo[7:0]};
      hit = (a == ABP);
      addrBus = a; aleStrobe = 1;
      tick();
      aleStrobe = 0;
      check("R1 ready in sampling window", ready, hit ? 0 : 1);
      check("R5 not stopped inside window", stopped, 0);
      tick();
      check("R5 stopped after window", stopped, hit ? 1 : 0);
      if (hit) begin
        tick();
        check("R5 stays stopped", stopped, 1);
        check("R1 ready held", ready, 0);
        step();
        check("R7 stop cleared", stopped, 0);
        check("R7 ready released", ready, 1);
        tick();
        check("R7 ready after release", ready, 1);
      end
    end

    // R1: matching address without latch strobe
    addrBus = ABP;
    tick(); tick();
    check("R1 no compare without strobe", ready, 1);
    check("R1 no stop without strobe", stopped, 0);

    // R8: address compare disabled
    addrEnable = 0; aleStrobe = 1;
    tick();
    aleStrobe = 0;
    check("R8 addr disabled ready", ready, 1);
    tick();
    check("R8 addr disabled stopped", stopped, 0);

    // R11: reload address breakpoint
    addrEnable = 1; addrBpLoad = 1; addrBpValue = ABP2;
    tick();
    addrBpLoad = 0;
    addrBus = ABP; aleStrobe = 1;
    tick();
    aleStrobe = 0;
    check("R11 old address ignored", ready, 1);
    addrBus = ABP2; aleStrobe = 1;
    tick();
    aleStrobe = 0;
    check("R11 new address hits", ready, 0);
    tick();
    check("R11 new address stops", stopped, 1);
    step();
    tick();
    addrEnable = 0;

    // R6: data hit mid-cycle, stop only after next latch strobe
    dataEnable = 1;
    addrBus = 16'h0100; aleStrobe = 1;
    tick();
    aleStrobe = 0;
    dataBus = DBP; wrStrobe = 1;
    tick();
    wrStrobe = 0; dataBus = 8'h00;
    check("R6 pending set mid-cycle", dataPendingN, 0);
    check("R4 ready low same clock", ready, 0);
    tick(); tick();
    check("R6 not stopped before window", stopped, 0);
    addrBus = 16'h0103; aleStrobe = 1;
    tick();
    aleStrobe = 0;
    check("R6 window clock not yet stopped", stopped, 0);
    tick();
    check("R6 stopped after next window", stopped, 1);

    // R12: hit and step together
    dataBus = DBP; rdStrobe = 1; stepPulse = 1;
    tick();
    stepPulse = 0; rdStrobe = 0; dataBus = 8'h00;
    check("R12 hit wins over step", dataPendingN, 0);
    check("R12 release still given", ready, 1);
    check("R12 stop cleared", stopped, 0);
    tick();
    check("R12 ready low after release", ready, 0);
    step();
    tick();
    dataEnable = 0;

    // R7: step mode re-asserts hold after one release clock
    stepMode = 1;
    tick();
    check("R7 step mode holds ready low", ready, 0);
    step();
    check("R7 step mode release", ready, 1);
    tick();
    check("R7 step mode re-hold", ready, 0);
    aleStrobe = 1;
    tick();
    aleStrobe = 0;
    tick();
    check("R7 step mode stops at window", stopped, 1);
    step();
    check("R7 step mode stop cleared", stopped, 0);
    stepMode = 0;
    tick();

    // R10: reset mid-operation
    dataEnable = 1; dataBus = DBP; rdStrobe = 1;
    tick();
    rdStrobe = 0;
    rst = 1;
    tick();
    rst = 0;
    check("R10 reset clears pending", dataPendingN, 1);
    check("R10 reset releases ready", ready, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule